// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block watches the data addresses a processor pipeline presents for loads and stores and raises a debug break request when an access falls inside a watched region. It holds a bank of `N` watch entries; each entry has a base-address register and a control register. The control register carries one bit that arms the entry for stores, one bit that arms it for loads, and a mask field in its low bits. The break request and the per-entry hit vector are combinational, so the pipeline sees them in the same cycle it presents the access. The pipeline uses that cycle to suppress the access before it completes.

The mask field covers the low `MASK_W` address bits. Bits of the effective mask above the field always read as one. A well-formed mask is a run of ones from the most significant bit down. The watched region starts at the base ANDed with that mask, and its size in bytes is the inverted mask plus one. If a mask has a hole, the compare logic keeps only the leading run of ones and clears every bit below the first zero. Reads still return the value exactly as it was written. One cycle after a hit, a registered cause output names the lowest-numbered entry that hit.

Registers are written through a port that carries a select, an entry index and data. A second, combinational port reads them back.

Top module: `dwp_unit`

## Requirements
- R1: An entry can hit a store only while bit 31 (store arm) of its control register is 1.
- R2: An entry can hit a load only while bit 30 (load arm) of its control register is 1.
- R3: An entry with both arm bits 0 never hits, whatever the address.
- R4: Control bits [MASK_W-1:0] form the mask field, and every effective-mask bit at or above MASK_W is 1. An armed entry hits when `(acc_addr & M) == (base & M)`, where M is the effective mask.
- R5: If the effective mask is not a run of ones from bit 31 downward, M keeps only the leading run of ones and every bit below the first zero is 0.
- R6: `hit_vec` and `brk_req` respond combinationally in the cycle `acc_valid` is high. Both are all zero while `acc_valid` is low. `brk_req` is high exactly when some bit of `hit_vec` is high.
- R7: A write with `sr_sel`=0 loads the base register and one with `sr_sel`=1 loads the control register of entry `sr_idx`. An access in the next cycle uses the new value. An access in the same cycle as the write uses the old value.
- R8: One clock after a cycle with hits, `cause_valid` is 1 and `cause_idx` is the lowest hit index. After a cycle with no hit, `cause_valid` is 0 and `cause_idx` keeps its value.
- R9: After reset every base and control register reads zero, no entry hits, and `cause_valid`/`cause_idx` are 0.
- R10: `rd_data` returns the raw stored word of entry `rd_idx`: the base when `rd_sel`=0, the control word when `rd_sel`=1. A control word with a holed mask reads back unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_wen | input | 1 | Register write strobe |
| sr_sel | input | 1 | 0 selects the base register, 1 selects the control register |
| sr_idx | input | IDX_W | Entry index for the write |
| sr_wdata | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 base, 1 control |
| rd_idx | input | IDX_W | Entry index for the read |
| rd_data | output | 32 | Raw stored register value |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | 32 | Access address |
| hit_vec | output | N | Per-entry hit, combinational |
| brk_req | output | 1 | Break request, combinational |
| cause_valid | output | 1 | Registered: the previous cycle had a hit |
| cause_idx | output | IDX_W | Registered lowest index that hit |

## Verification
A stored base or control word that is wrong shows up in `rd_data` at once. It also shows up in `hit_vec` on the first access whose address lies near the region's edge. A fault in the mask truncation appears as a hit or a miss for addresses between the holed mask's bits and the truncated boundary, so the stimulus aims accesses just inside and just outside each region. A priority or cause-register fault shows in `cause_idx` exactly one cycle after any multi-entry hit, and the stimulus overlaps entries on purpose so that such hits occur.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
  parameter int unsigned DATA_W = 32;
  localparam int unsigned ST_ARM_BIT = DATA_W - 1;
  localparam int unsigned LD_ARM_BIT = DATA_W - 2;

  typedef logic [DATA_W-1:0] word_t;

  // effective mask before truncation: mask field with upper bits forced to one
  function automatic word_t raw_mask(input word_t ctrl, input int unsigned mw);
    word_t field;
    field = (word_t'(1) << mw) - word_t'(1);
    return ctrl | ~field;
  endfunction

  // keep only the leading run of ones from the top bit down
  function automatic word_t trunc_mask(input word_t m);
    word_t r;
    logic  run;
    run = 1'b1;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      run  = run & m[b];
      r[b] = run;
    end
    return r;
  endfunction

  function automatic logic in_region(input word_t a, input word_t base, input word_t m);
    return ((a ^ base) & m) == '0;
  endfunction
endpackage

// File: rtl/dwp_entry.sv
module dwp_entry
  import dwp_pkg::*;
#(
  parameter int unsigned MASK_W = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_base,
  input  logic  wr_ctrl,
  input  word_t wdata,
  input  logic  acc_valid,
  input  logic  acc_is_store,
  input  word_t acc_addr,
  output word_t base_q,
  output word_t ctrl_q,
  output logic  st_arm,
  output logic  ld_arm,
  output logic  hit
);
  word_t eff_mask;
  logic  type_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata;
    end
  end

  assign st_arm   = ctrl_q[ST_ARM_BIT];
  assign ld_arm   = ctrl_q[LD_ARM_BIT];
  assign eff_mask = trunc_mask(raw_mask(ctrl_q, MASK_W));
  assign type_ok  = acc_is_store ? st_arm : ld_arm;
  assign hit      = acc_valid & type_ok & in_region(acc_addr, base_q, eff_mask);
endmodule

// File: rtl/dwp_first.sv
module dwp_first #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[k]) begin
        any = 1'b1;
        idx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/dwp_unit.sv
module dwp_unit
  import dwp_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned MASK_W = 6,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_wen,
  input  logic              sr_sel,
  input  logic [IDX_W-1:0]  sr_idx,
  input  logic [DATA_W-1:0] sr_wdata,
  input  logic              rd_sel,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              acc_valid,
  input  logic              acc_is_store,
  input  logic [DATA_W-1:0] acc_addr,
  output logic [N-1:0]      hit_vec,
  output logic              brk_req,
  output logic              cause_valid,
  output logic [IDX_W-1:0]  cause_idx
);
  word_t            base_arr [N];
  word_t            ctrl_arr [N];
  logic [N-1:0]     st_arm_vec;
  logic [N-1:0]     ld_arm_vec;
  logic [N*DATA_W-1:0] ctrl_flat;
  logic             any_hit;
  logic [IDX_W-1:0] first_idx;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic sel_me;
    assign sel_me = sr_wen && (sr_idx == IDX_W'(i));
    dwp_entry #(.MASK_W(MASK_W)) u_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_base     (sel_me && !sr_sel),
      .wr_ctrl     (sel_me && sr_sel),
      .wdata       (sr_wdata),
      .acc_valid   (acc_valid),
      .acc_is_store(acc_is_store),
      .acc_addr    (acc_addr),
      .base_q      (base_arr[i]),
      .ctrl_q      (ctrl_arr[i]),
      .st_arm      (st_arm_vec[i]),
      .ld_arm      (ld_arm_vec[i]),
      .hit         (hit_vec[i])
    );
    assign ctrl_flat[i*DATA_W +: DATA_W] = ctrl_arr[i];
  end

  dwp_first #(.N(N), .IDX_W(IDX_W)) u_first (
    .vec(hit_vec),
    .any(any_hit),
    .idx(first_idx)
  );

  assign brk_req = any_hit;

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < N; k++) begin
      if (rd_idx == IDX_W'(k)) rd_data = rd_sel ? ctrl_arr[k] : base_arr[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_valid <= 1'b0;
      cause_idx   <= '0;
    end else begin
      cause_valid <= any_hit;
      if (any_hit) cause_idx <= first_idx;
    end
  end
endmodule

// File: rtl/dwp_unit_chk.sv
module dwp_unit_chk #(
  parameter int unsigned N      = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sr_wen,
  input logic              sr_sel,
  input logic [IDX_W-1:0]  sr_idx,
  input logic [DATA_W-1:0] sr_wdata,
  input logic              acc_valid,
  input logic              acc_is_store,
  input logic [N-1:0]      hit_vec,
  input logic              brk_req,
  input logic [N-1:0]      st_arm_vec,
  input logic [N-1:0]      ld_arm_vec,
  input logic [N*DATA_W-1:0] ctrl_flat,
  input logic              cause_valid,
  input logic [IDX_W-1:0]  cause_idx
);
  logic [N-1:0] prev_hit;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_hit <= '0;
    else        prev_hit <= hit_vec;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_store_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_is_store && hit_vec[i]) |-> st_arm_vec[i]);
    p_load_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_is_store && hit_vec[i]) |-> ld_arm_vec[i]);
    p_disarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_arm_vec[i] || ld_arm_vec[i]) |-> !hit_vec[i]);
    p_ctrl_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wen && sr_sel && sr_idx == IDX_W'(i)) |=>
        ctrl_flat[i*DATA_W +: DATA_W] == $past(sr_wdata));
  end

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (hit_vec == '0 && !brk_req));
  p_brk_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> hit_vec != '0);
  p_cause_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cause_valid |-> prev_hit[cause_idx]);
  p_cause_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cause_valid |-> (prev_hit & ((N'(1) << cause_idx) - N'(1))) == '0);
  p_cause_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_valid |-> prev_hit == '0);
endmodule

bind dwp_unit dwp_unit_chk #(.N(N), .DATA_W(dwp_pkg::DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sr_wen      (sr_wen),
  .sr_sel      (sr_sel),
  .sr_idx      (sr_idx),
  .sr_wdata    (sr_wdata),
  .acc_valid   (acc_valid),
  .acc_is_store(acc_is_store),
  .hit_vec     (hit_vec),
  .brk_req     (brk_req),
  .st_arm_vec  (st_arm_vec),
  .ld_arm_vec  (ld_arm_vec),
  .ctrl_flat   (ctrl_flat),
  .cause_valid (cause_valid),
  .cause_idx   (cause_idx)
);

// File: tb/tb_dwp_unit.sv
module tb_dwp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NE  = 4;
  localparam int MW  = 6;
  localparam int IW  = 2;
  localparam logic [31:0] ST = 32'h8000_0000;
  localparam logic [31:0] LD = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_wen = 1'b0, sr_sel = 1'b0;
  logic [IW-1:0] sr_idx = '0;
  logic [31:0] sr_wdata = '0;
  logic rd_sel = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [31:0] rd_data;
  logic acc_valid = 1'b0, acc_is_store = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [NE-1:0] hit_vec;
  logic brk_req, cause_valid;
  logic [IW-1:0] cause_idx;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_base [NE];
  logic [31:0] m_ctrl [NE];
  logic [IW-1:0] exp_cidx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwp_unit #(.N(NE), .MASK_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .sr_wen(sr_wen), .sr_sel(sr_sel), .sr_idx(sr_idx),
    .sr_wdata(sr_wdata), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .acc_valid(acc_valid), .acc_is_store(acc_is_store), .acc_addr(acc_addr),
    .hit_vec(hit_vec), .brk_req(brk_req), .cause_valid(cause_valid), .cause_idx(cause_idx)
  );

  // mask by counting leading ones of the forced word
  function automatic logic [31:0] bmask(input logic [31:0] c);
    logic [31:0] raw;
    int lo;
    raw = c | ~((32'd1 << MW) - 32'd1);
    lo = 0;
    while (lo < 32 && raw[31-lo]) lo++;
    return (lo == 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> lo);
  endfunction

  function automatic logic [NE-1:0] exp_hits(input logic v, input logic st, input logic [31:0] a);
    logic [NE-1:0] r;
    for (int i = 0; i < NE; i++) begin
      logic en;
      logic [31:0] m;
      en = st ? m_ctrl[i][31] : m_ctrl[i][30];
      m = bmask(m_ctrl[i]);
      r[i] = v && en && ((a & m) == (m_base[i] & m));
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, check comb outputs, then registered cause
  task automatic cyc(input logic wen, input logic sel, input int idx, input logic [31:0] wd,
                     input logic av, input logic st, input logic [31:0] aa, input string tag);
    logic [NE-1:0] eh;
    int lowest;
    @(negedge clk);
    sr_wen = wen; sr_sel = sel; sr_idx = IW'(idx); sr_wdata = wd;
    acc_valid = av; acc_is_store = st; acc_addr = aa;
    #1;
    eh = exp_hits(av, st, aa);
    chk({tag, " hit_vec"}, 32'(hit_vec), 32'(eh));
    chk("R6 brk_req", 32'(brk_req), 32'(|eh));
    @(posedge clk);
    if (wen) begin
      if (sel) m_ctrl[idx] = wd; else m_base[idx] = wd;
    end
    lowest = -1;
    for (int i = NE - 1; i >= 0; i--) if (eh[i]) lowest = i;
    if (lowest >= 0) exp_cidx = IW'(lowest);
    #1;
    chk("R8 cause_valid", 32'(cause_valid), 32'(lowest >= 0));
    chk("R8 cause_idx", 32'(cause_idx), 32'(exp_cidx));
  endtask

  task automatic wr(input int idx, input logic sel, input logic [31:0] d);
    cyc(1'b1, sel, idx, d, 1'b0, 1'b0, 32'h0, "R7");
  endtask

  task automatic rdchk(input int idx, input logic sel, input string tag);
    @(negedge clk);
    sr_wen = 1'b0; acc_valid = 1'b0;
    rd_idx = IW'(idx); rd_sel = sel;
    #1;
    chk(tag, rd_data, sel ? m_ctrl[idx] : m_base[idx]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] seed;
    seed = 32'd12345;
    void'($urandom(seed));
    for (int i = 0; i < NE; i++) begin m_base[i] = '0; m_ctrl[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R9 reset state
    chk("R9 cause_valid", 32'(cause_valid), 32'h0);
    chk("R9 cause_idx", 32'(cause_idx), 32'h0);
    for (int i = 0; i < NE; i++) begin rdchk(i, 1'b0, "R9 base"); rdchk(i, 1'b1, "R9 ctrl"); end
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b1, 32'h0, "R9");
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 32'h0, "R9");

    // R1: store-only entry, 16-byte region at 0x1000
    wr(0, 1'b0, 32'h0000_1000);
    wr(0, 1'b1, ST | 32'h30);
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b1, 32'h0000_100C, "R1");
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 32'h0000_100C, "R2");
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b1, 32'h0000_1010, "R4");
    cyc(1'b0, 1'b0, 0, 0, 1'b0, 1'b1, 32'h0000_1000, "R6");
    // R4: field bits above MASK_W forced one
    wr(1, 1'b0, 32'h0000_0040);
    wr(1, 1'b1, LD | 32'h0FFF_FFC0);
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 32'h0000_0040, "R4");
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 32'h0000_0140, "R4");
    // R5: holed mask 101101 -> 32-byte region
    wr(2, 1'b0, 32'h0000_2000);
    wr(2, 1'b1, LD | 32'h2D);
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 32'h0000_2013, "R5");
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 32'h0000_201F, "R5");
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 32'h0000_2020, "R5");
    rdchk(2, 1'b1, "R10 raw holed ctrl");
    // R3: disarm with mask bits still set
    wr(2, 1'b1, 32'h0000_002D);
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 32'h0000_2013, "R3");
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b1, 32'h0000_2013, "R3");
    // R8 priority: entries 1 and 3 overlap
    wr(3, 1'b0, 32'h0000_0040);
    wr(3, 1'b1, LD | ST | 32'h3F);
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 32'h0000_0040, "R8");
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b1, 32'h0000_0040, "R8");
    cyc(1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 32'h0000_0000, "R8");
    // R7: write in same cycle as access uses old value, next cycle new
    cyc(1'b1, 1'b0, 3, 32'h0000_5000, 1'b1, 1'b1, 32'h0000_0040, "R7");
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b1, 32'h0000_0040, "R7");
    cyc(1'b0, 1'b0, 0, 0, 1'b1, 1'b1, 32'h0000_5000, "R7");
    rdchk(3, 1'b0, "R10 base");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 3) begin
        int e;
        logic [31:0] d;
        e = int'($urandom_range(0, NE - 1));
        if (r == 0) begin
          d = {16'h0, 4'h0, 4'($urandom_range(0, 3)), 8'($urandom)};
          wr(e, 1'b0, d);
        end else begin
          d = {2'($urandom), 24'($urandom), 6'($urandom)};
          if ($urandom_range(0, 1) == 1) d[5:0] = 6'h3F << $urandom_range(0, 6);
          wr(e, 1'b1, d);
        end
      end else begin
        int e;
        logic [31:0] a;
        e = int'($urandom_range(0, NE - 1));
        a = m_base[e] + 32'($signed(8'($urandom)) >>> 1);
        cyc(1'b0, 1'b0, 0, 0, 1'($urandom), 1'($urandom), a, "R4");
      end
      if (it % 50 == 0) rdchk(int'($urandom_range(0, NE - 1)), 1'($urandom), "R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule